// File: doc/BRIEF.md
# Bit-Serial GHASH Field Multiplier

This block multiplies two 128-bit values in the binary field used by Galois/Counter Mode authentication. It handles one multiplier bit per clock, so each product takes 128 stepping cycles. It uses the bit-reflected convention. On entry and on exit, every byte has its bit order reversed while keeping its byte position. The shifted multiplicand is reduced by folding the constant 0x87 into its low byte whenever its top bit falls off.

Two operations are available. In hash-step mode, the running digest (`acc_i`) is combined by XOR with a data block (`data_i`), and that sum is multiplied by the hash subkey (`key_i`). In plain-multiply mode, the digest is multiplied by the subkey directly and the data block is not used. Each 128-bit operand is made of four 32-bit elements. Element k sits in bits [32k+31:32k]. The caller pulses `start_i` while the unit is idle, waits for the one-cycle `done_o`, and then reads `result_o`. The result stays on `result_o` until the next product completes.

Top module: `ghash_serial_mul`

## Requirements
- R1: While reset is active and after it is released, `busy_o` and `done_o` are 0 and `result_o` is all zeros until a product completes.
- R2: With `mode_i`=1 (hash-step), the result is computed as follows:
  - Let S = brev8(acc_i ^ data_i) and H = brev8(key_i), and set Z = 0.
  - For b = 0..127: if S[b] is 1, Z ^= H. Then H shifts left by one, and if the bit shifted out was 1, the low byte of H is XORed with 0x87.
  - The result is brev8(Z). Here brev8 reverses the bits inside each byte and keeps every byte in place.
- R3: With `mode_i`=0 (plain multiply), the result is the same computation with S = brev8(acc_i), and `data_i` has no effect. In particular, `acc_i` = 128'h80 returns `key_i` unchanged.
- R4: A zero multiplier or a zero subkey gives an all-zero result.
- R5: `done_o` rises exactly 128 clock edges after the edge that accepts a start, and it stays high for exactly one cycle.
- R6: `busy_o` is high from the edge after an accepted start until the edge at which `done_o` rises. It is never high in the same cycle as `done_o`.
- R7: A start request that arrives while `busy_o` is high is ignored. The running product, its operands and its completion time are unchanged.
- R8: `result_o` changes only at the edge where `done_o` rises, and it holds its value at all other times.
- R9: Reduction is correct when the subkey drives bit 127 of H high, including the all-ones operands. A nonzero H stays nonzero through every step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, accepted only when idle |
| mode_i | input | 1 | 1 = hash-step (acc^data)*key, 0 = plain multiply acc*key |
| acc_i | input | 128 | Running digest operand, four 32-bit elements |
| data_i | input | 128 | Data block operand, used in hash-step mode |
| key_i | input | 128 | Hash subkey operand |
| busy_o | output | 1 | Multiplication in progress |
| done_o | output | 1 | One-cycle pulse when the result is updated |
| result_o | output | 128 | Product, held until the next completion |

## Verification
Some properties are checked by assertions on every cycle:
- `done_o` is a single-cycle pulse that never overlaps `busy_o`.
- The step counter advances by exactly one per busy cycle, whatever `start_i` does.
- The final step is always followed by `done_o`.
- `result_o` is stable except in a done cycle.
- A nonzero multiplicand never collapses to zero under reduction.

Other behaviours can only be shown by the bench's scenarios, because they depend on comparing values against an independent reference product:
- Field arithmetic for each mode.
- The plain-multiply identity.
- Zero, all-ones and top-bit subkeys.
- That a start request during a run is ignored.

// File: rtl/ghash_pkg.sv
package ghash_pkg;
  localparam int unsigned BLK_W   = 128;
  localparam int unsigned LANE_W  = 32;
  localparam int unsigned N_LANES = BLK_W / LANE_W;
  localparam logic [7:0]  RED_LOW = 8'h87;

  typedef enum logic {
    MODE_MUL  = 1'b0,
    MODE_HASH = 1'b1
  } ghash_mode_e;
endpackage

// File: rtl/ghash_brev8.sv
module ghash_brev8 #(
  parameter int unsigned W = 128
) (
  input  logic [W-1:0] in_i,
  output logic [W-1:0] out_o
);
  localparam int unsigned NBYTES = W / 8;

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    for (genvar k = 0; k < 8; k++) begin : g_bit
      assign out_o[8*g + k] = in_i[8*g + 7 - k];
    end
  end
endmodule

// File: rtl/ghash_ctrl.sv
module ghash_ctrl #(
  parameter int unsigned STEPS = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic last_o,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CW = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [CW-1:0] LAST_CNT = CW'(STEPS - 1);

  logic          busy_q, busy_d;
  logic          done_q, done_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          last;

  assign last   = (cnt_q == LAST_CNT);
  assign load_o = start_i && !busy_q;
  assign step_o = busy_q;
  assign last_o = busy_q && last;
  assign busy_o = busy_q;
  assign done_o = done_q;
  assign cnt_en = load_o || busy_q;

  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    cnt_d  = cnt_q;
    if (load_o) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (busy_q) begin
      if (last) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // R7
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last) |=> (busy_q && (cnt_q == $past(cnt_q) + CW'(1))));

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R5
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && last) |=> done_q);

  // R6
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);
endmodule

// File: rtl/ghash_datapath.sv
module ghash_datapath #(
  parameter int unsigned W       = 128,
  parameter logic [7:0]  RED_LOW = 8'h87
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] s_init_i,
  input  logic [W-1:0] h_init_i,
  output logic [W-1:0] z_nxt_o
);
  localparam logic [W-1:0] RED_VEC = {{(W-8){1'b0}}, RED_LOW};

  logic [W-1:0] s_q, s_d;
  logic [W-1:0] h_q, h_d;
  logic [W-1:0] z_q, z_d;
  logic [W-1:0] h_shift;
  logic [W-1:0] z_acc;
  logic         reg_en;

  assign reg_en  = load_i || step_i;
  assign h_shift = {h_q[W-2:0], 1'b0} ^ (h_q[W-1] ? RED_VEC : '0);
  assign z_acc   = z_q ^ (s_q[0] ? h_q : '0);
  assign z_nxt_o = z_acc;

  always_comb begin
    s_d = s_q;
    h_d = h_q;
    z_d = z_q;
    if (load_i) begin
      s_d = s_init_i;
      h_d = h_init_i;
      z_d = '0;
    end else if (step_i) begin
      s_d = {1'b0, s_q[W-1:1]};
      h_d = h_shift;
      z_d = z_acc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_q <= '0;
      h_q <= '0;
      z_q <= '0;
    end else if (reg_en) begin
      s_q <= s_d;
      h_q <= h_d;
      z_q <= z_d;
    end
  end

  // R9
  h_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && (h_q != '0)) |=> (h_q != '0));
endmodule

// File: rtl/ghash_serial_mul.sv
module ghash_serial_mul
  import ghash_pkg::*;
#(
  parameter int unsigned W = BLK_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         mode_i,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] key_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] result_o
);
  logic         load, step, last;
  logic [W-1:0] mult_src;
  logic [W-1:0] s_init, h_init;
  logic [W-1:0] z_nxt, z_out;
  logic [W-1:0] res_q;

  assign mult_src = (ghash_mode_e'(mode_i) == MODE_HASH) ? (acc_i ^ data_i) : acc_i;

  ghash_brev8 #(.W(W)) u_rev_s (.in_i(mult_src), .out_o(s_init));
  ghash_brev8 #(.W(W)) u_rev_h (.in_i(key_i),    .out_o(h_init));
  ghash_brev8 #(.W(W)) u_rev_z (.in_i(z_nxt),    .out_o(z_out));

  ghash_ctrl #(.STEPS(W)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(start_i),
    .load_o (load),
    .step_o (step),
    .last_o (last),
    .busy_o (busy_o),
    .done_o (done_o)
  );

  ghash_datapath #(.W(W), .RED_LOW(RED_LOW)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load),
    .step_i  (step),
    .s_init_i(s_init),
    .h_init_i(h_init),
    .z_nxt_o (z_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else if (last) begin
      res_q <= z_out;
    end
  end

  assign result_o = res_q;

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(result_o));
endmodule

// File: tb/tb_ghash_serial_mul.sv
`timescale 1ns/1ps
module tb_ghash_serial_mul;
  logic         clk;
  logic         rst_n;
  logic         start_i;
  logic         mode_i;
  logic [127:0] acc_i, data_i, key_i;
  logic         busy_o, done_o;
  logic [127:0] result_o;

  int checks;
  int failures;
  string cur_req;

  ghash_serial_mul dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .acc_i(acc_i), .data_i(data_i), .key_i(key_i),
    .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [127:0] brev(input logic [127:0] v);
    logic [127:0] r;
    for (int i = 0; i < 128; i++) r[i] = v[(i/8)*8 + 7 - (i%8)];
    return r;
  endfunction

  function automatic logic [127:0] gf_ref(input logic m, input logic [127:0] y,
                                          input logic [127:0] x, input logic [127:0] k);
    logic [127:0] s, h, z;
    logic top;
    s = brev(m ? (y ^ x) : y);
    h = brev(k);
    z = '0;
    for (int b = 0; b < 128; b++) begin
      if (s[b]) z = z ^ h;
      top = h[127];
      h = h << 1;
      if (top) h[7:0] = h[7:0] ^ 8'h87;
    end
    return brev(z);
  endfunction

  // reference model
  bit           m_busy, m_done;
  int           remain;
  logic [127:0] m_res, m_pend;

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; remain = 0; m_res = '0; m_pend = '0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        remain--;
        if (remain == 0) begin
          m_busy = 0; m_done = 1; m_res = m_pend;
        end
      end else if (start_i) begin
        m_busy = 1; remain = 128;
        m_pend = gf_ref(mode_i, acc_i, data_i, key_i);
      end
    end
    #1;
    if (rst_n) begin
      chk("R6", {127'b0, busy_o}, {127'b0, m_busy});
      chk("R5", {127'b0, done_o}, {127'b0, m_done});
      chk(m_done ? cur_req : "R8", result_o, m_res);
    end
  end

  task automatic do_op(input logic m, input logic [127:0] y, input logic [127:0] x,
                       input logic [127:0] k, input string req, input int intr_at);
    @(negedge clk);
    cur_req = req;
    mode_i = m; acc_i = y; data_i = x; key_i = k; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 1; i <= 130; i++) begin
      if (i == intr_at) begin
        mode_i = ~m; acc_i = ~y; data_i = 128'h1234; key_i = ~k; start_i = 1'b1;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    checks = 0; failures = 0; cur_req = "R2";
    rst_n = 1'b0; start_i = 1'b0; mode_i = 1'b0;
    acc_i = '0; data_i = '0; key_i = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", {126'b0, busy_o, done_o}, 128'b0);
    chk("R1", result_o, 128'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", result_o, 128'b0);

    // R2 hash-step, random and fixed operands
    do_op(1'b1, {$urandom, $urandom, $urandom, $urandom},
          {$urandom, $urandom, $urandom, $urandom},
          {$urandom, $urandom, $urandom, $urandom}, "R2", 0);
    do_op(1'b1, 128'h0123456789abcdef_fedcba9876543210,
          128'h00112233445566778899aabbccddeeff,
          128'h66e94bd4ef8a2c3b884cfa59ca342b2e, "R2", 0);
    // R3 plain multiply: identity and ignored data
    do_op(1'b0, 128'h80, 128'hdeadbeef, 128'hcafef00d_11223344_55667788_99aabbcc, "R3", 0);
    chk("R3", result_o, 128'hcafef00d_11223344_55667788_99aabbcc);
    do_op(1'b0, {$urandom, $urandom, $urandom, $urandom},
          {$urandom, $urandom, $urandom, $urandom},
          {$urandom, $urandom, $urandom, $urandom}, "R3", 0);
    // R4 zero operands
    do_op(1'b1, 128'h5555, 128'h5555, 128'hffff0000, "R4", 0);
    chk("R4", result_o, 128'b0);
    do_op(1'b0, 128'habcdef, 128'h0, 128'h0, "R4", 0);
    chk("R4", result_o, 128'b0);
    // R9 reduction boundary and all-ones
    do_op(1'b0, {128{1'b1}}, 128'h0, 128'h01 << 120, "R9", 0);
    do_op(1'b1, {128{1'b1}}, 128'h0, {128{1'b1}}, "R9", 0);
    do_op(1'b0, 128'h80 << 120, 128'h0, 128'h01 << 120, "R9", 0);
    // R7 start while busy ignored
    do_op(1'b1, 128'h0f0f, 128'hf0f0_0000, 128'h1357_9bdf, "R7", 10);
    do_op(1'b0, {$urandom, $urandom, $urandom, $urandom}, 128'h0,
          {$urandom, $urandom, $urandom, $urandom}, "R7", 127);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule